// File: doc/BRIEF.md
# Coin-Totalling Vend Controller

This block decides when a single item may be released from a coin-fed vending unit. Each time a coin is detected, the coin's value is added to an internal running total. Once the total covers the item price and no coin is arriving, the block pulses its vend output for one cycle. It then clears the total and starts collecting again.

The design is split into a control part and a data part. A four-state controller never handles coin values directly. It only issues load and clear commands to a total register fed by a saturating adder. It reads back a single bit from a less-than comparator that checks the total against the price. Returning change, checking coin validity and storing the price are handled outside this block.

Top module: `coin_vend_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller enters its start state (encoding 2'b00), the total becomes 0 and `vend_out` is 0 in the following cycle.
- R2: The start state clears the total to 0 and always moves to the waiting state (2'b01) at the next edge.
- R3: A coin seen in the waiting state moves the controller to the adding state (2'b10). In that adding cycle the total loads total + `coin_amt`, using the value `coin_amt` holds during the adding cycle. The controller then returns to waiting.
- R4: In the waiting state, `coin_seen` high takes priority over the vend decision, even when the total already covers the price.
- R5: In the waiting state with `coin_seen` low, the controller moves to the vend state (2'b11) when total >= `item_cost`, equality included. Otherwise it stays waiting.
- R6: `vend_out` is high for exactly one cycle per vend, in the cycle the controller is in the vend state. The next state is the start state, so the next vend needs fresh coins.
- R7: The addition saturates at 2^WIDTH-1 (255 by default) rather than wrapping.
- R8: When `coin_seen` is held high, one coin is counted in every waiting cycle in which it is high. Held high from a waiting cycle for 2N cycles, it therefore adds N coins.
- R9: With `item_cost` = 0 and no coins, the block vends every third cycle: start, waiting, vend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coin_seen | input | 1 | High in a cycle in which a coin is detected |
| coin_amt | input | WIDTH | Value of the current coin, taken in the adding cycle |
| item_cost | input | WIDTH | Price of one item |
| vend_out | output | 1 | One-cycle vend pulse, registered |

## Verification
The hardest case to reach from the ports is the adding cycle. There, the coin value must be present one cycle after the coin pulse and not in the pulse cycle. The bench follows its own model of the controller state, so it places the coin pulse only in a waiting cycle. It zeroes `coin_amt` during the pulse and presents the real value in the next cycle. Saturation needs two large coins against a price near full scale. Coin priority needs `coin_seen` held high after the price is already covered, which the held-coin and random phases provide.

// File: rtl/vend_pkg.sv
// Package: shared controller state type for the vend controller.
// Assumes a two-bit state encoding; the order below is the documented encoding.
package vend_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'b00,
        ST_WAIT  = 2'b01,
        ST_ADD   = 2'b10,
        ST_VEND  = 2'b11
    } vend_state_t;

endpackage

// File: rtl/vend_tally.sv
// Module: vend_tally
// Running-total register with a saturating adder in front of it.
// Assumes clear and load may arrive together; clear wins.
module vend_tally #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tot_ld,
    input  logic             tot_clr,
    input  logic [WIDTH-1:0] amt,
    output logic [WIDTH-1:0] tot
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH:0]   wide_sum;
    logic [WIDTH-1:0] sat_sum;

    // Widened add, then clamp to full scale on carry out.
    always_comb begin
        wide_sum = {1'b0, tot} + {1'b0, amt};
        sat_sum  = wide_sum[WIDTH] ? TOP : wide_sum[WIDTH-1:0];
    end

    // Total register: reset and clear zero it, load takes the clamped sum.
    always_ff @(posedge clk) begin
        if (!rst_n || tot_clr) begin
            tot <= '0;
        end else if (tot_ld) begin
            tot <= sat_sum;
        end
    end

endmodule

// File: rtl/vend_cmp.sv
// Module: vend_cmp
// Unsigned less-than comparator reporting total below price.
// Assumes both operands are unsigned and of equal width.
module vend_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] tot,
    input  logic [WIDTH-1:0] cost,
    output logic             below
);
    // Single status bit handed to the controller.
    always_comb begin
        below = (tot < cost);
    end

endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl
// Four-state controller; drives load/clear of the total and the vend pulse.
// Assumes it sees only the below-price bit, never the total itself.
module vend_ctrl
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        coin,
    input  logic        below,
    output vend_state_t state,
    output logic        tot_ld,
    output logic        tot_clr,
    output logic        vend
);
    vend_state_t nxt;

    // Next-state choice; a coin beats the vend decision while waiting.
    always_comb begin
        unique case (state)
            ST_START: nxt = ST_WAIT;
            ST_WAIT:  nxt = coin ? ST_ADD : (below ? ST_WAIT : ST_VEND);
            ST_ADD:   nxt = ST_WAIT;
            default:  nxt = ST_START;
        endcase
    end

    // Datapath commands decoded from the present state.
    always_comb begin
        tot_clr = (state == ST_START);
        tot_ld  = (state == ST_ADD);
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_START;
        end else begin
            state <= nxt;
        end
    end

    // Registered vend pulse, high exactly while in the vend state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vend <= 1'b0;
        end else begin
            vend <= (nxt == ST_VEND);
        end
    end

endmodule

// File: rtl/coin_vend_top.sv
// Module: coin_vend_top
// Coin-totalling vend controller: controller plus total/compare datapath.
// Assumes coin_amt is valid in the cycle after the coin pulse.
module coin_vend_top
    import vend_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coin_seen,
    input  logic [WIDTH-1:0] coin_amt,
    input  logic [WIDTH-1:0] item_cost,
    output logic             vend_out
);
    vend_state_t      st;
    logic             ld;
    logic             clr;
    logic             lt_cost;
    logic [WIDTH-1:0] tot_val;

    vend_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .coin    (coin_seen),
        .below   (lt_cost),
        .state   (st),
        .tot_ld  (ld),
        .tot_clr (clr),
        .vend    (vend_out)
    );

    vend_tally #(.WIDTH(WIDTH)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .tot_ld  (ld),
        .tot_clr (clr),
        .amt     (coin_amt),
        .tot     (tot_val)
    );

    vend_cmp #(.WIDTH(WIDTH)) u_cmp (
        .tot   (tot_val),
        .cost  (item_cost),
        .below (lt_cost)
    );

endmodule

// File: rtl/vend_chk.sv
// Module: vend_chk
// Property checker bound into coin_vend_top; observes state, total and pulse.
// Assumes the synchronous active-low reset is applied at start of run.
module vend_chk
    import vend_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             coin_seen,
    input vend_state_t      st,
    input logic [WIDTH-1:0] tot_val,
    input logic [WIDTH-1:0] item_cost,
    input logic             vend_out
);
    // R1
    reset_start_chk: assert property (@(posedge clk)
        !rst_n |=> (st == ST_START && tot_val == '0 && !vend_out));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_START |=> (st == ST_WAIT && tot_val == '0));

    // R3
    add_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ADD |=> (st == ST_WAIT && tot_val >= $past(tot_val)));

    // R4
    coin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && coin_seen) |=> st == ST_ADD);

    // R5
    covered_vend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !coin_seen && tot_val >= item_cost) |=> st == ST_VEND);

    // R6
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vend_out |=> (!vend_out && st == ST_START));

    // R6
    pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vend_out |-> st == ST_VEND);

endmodule

bind coin_vend_top vend_chk #(.WIDTH(WIDTH)) u_vend_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .coin_seen (coin_seen),
    .st        (st),
    .tot_val   (tot_val),
    .item_cost (item_cost),
    .vend_out  (vend_out)
);

// File: tb/tb_coin_vend_top.sv
module tb_coin_vend_top;
    localparam int W = 8;
    localparam int MAXV = 255;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         coin_seen = 1'b0;
    logic [W-1:0] coin_amt = '0;
    logic [W-1:0] item_cost = '0;
    logic         vend_out;

    int total = 0;
    int bad = 0;
    int m_st = 0;
    int m_tot = 0;
    int vends = 0;
    int cycles = 0;
    string cur_req = "R1";

    coin_vend_top #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .coin_seen(coin_seen),
        .coin_amt(coin_amt), .item_cost(item_cost), .vend_out(vend_out)
    );

    always #4 clk = ~clk;

    // Behavioural reference: 0 start, 1 wait, 2 add, 3 vend.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tot = 0;
        end else begin
            case (m_st)
                0: begin m_tot = 0; m_st = 1; end
                1: if (coin_seen) m_st = 2;
                   else if (m_tot >= int'(item_cost)) m_st = 3;
                2: begin
                    m_tot = m_tot + int'(coin_amt);
                    if (m_tot > MAXV) m_tot = MAXV;
                    m_st = 1;
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the vend pulse against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'(vend_out), (m_st == 3) ? 1 : 0);
            if (vend_out) vends++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; coin_seen = 1'b0; coin_amt = '0;
        step(3);
        rst_n = 1'b1;
    endtask

    // Pulse a coin in a waiting cycle; value only in the adding cycle.
    task automatic give_coin(int v);
        while (m_st != 1) step(1);
        coin_seen = 1'b1; coin_amt = '0;
        step(1);
        coin_seen = 1'b0; coin_amt = W'(v);
        step(1);
        coin_amt = '0;
    endtask

    initial begin
        int v0;
        item_cost = 8'd50;
        cur_req = "R1";
        step(2);
        check("R1", int'(vend_out), 0);
        do_reset();

        // R2/R5: two coins meet the price exactly -> one vend
        cur_req = "R5";
        v0 = vends;
        give_coin(25); give_coin(25);
        step(6);
        check("R5", vends - v0, 1);

        // R6: after a vend the total is cleared, no further vends
        cur_req = "R6";
        v0 = vends;
        step(12);
        check("R6", vends - v0, 0);

        // R5: short of price then exact
        cur_req = "R5";
        item_cost = 8'd60;
        v0 = vends;
        give_coin(25); give_coin(25);
        step(5);
        check("R5", vends - v0, 0);
        give_coin(10);
        step(5);
        check("R5", vends - v0, 1);

        // R3: value zero during pulse, real value during adding cycle
        cur_req = "R3";
        item_cost = 8'd40;
        v0 = vends;
        give_coin(40);
        step(5);
        check("R3", vends - v0, 1);

        // R8 / R4: coin held for 6 cycles from waiting -> 3 coins
        cur_req = "R8";
        item_cost = 8'd31;
        while (m_st != 1) step(1);
        coin_amt = 8'd10; coin_seen = 1'b1;
        v0 = vends;
        step(6);
        coin_seen = 1'b0;
        step(6);
        check("R8", vends - v0, 0);
        cur_req = "R4";
        item_cost = 8'd20;
        coin_seen = 1'b1;
        v0 = vends;
        step(8);
        check("R4", vends - v0, 0);
        coin_seen = 1'b0; coin_amt = '0;
        step(5);
        check("R4", vends - v0, 1);

        // R7: saturation against a full-scale price
        cur_req = "R7";
        do_reset();
        item_cost = 8'd255;
        v0 = vends;
        give_coin(200); give_coin(200);
        step(5);
        check("R7", vends - v0, 1);

        // R9: zero price vends every third cycle
        cur_req = "R9";
        item_cost = 8'd0;
        do_reset();
        v0 = vends;
        step(30);
        check("R9", vends - v0, 10);

        // R1: reset in mid-collection drops the total
        cur_req = "R1";
        item_cost = 8'd30;
        give_coin(20);
        do_reset();
        v0 = vends;
        give_coin(15);
        step(6);
        check("R1", vends - v0, 0);

        // Random phase, model compared every cycle
        cur_req = "R4";
        for (int k = 0; k < 3000; k++) begin
            coin_seen = ($urandom_range(0, 3) == 0);
            coin_amt  = W'($urandom_range(0, 255));
            if (k % 500 == 0) item_cost = W'($urandom_range(0, 255));
            step(1);
        end
        coin_seen = 1'b0;
        step(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule